// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of a small 8-bit controller and picks its next value once per clock. The instruction decoder outside the block supplies already-decoded selects. In any cycle the counter is cleared, loaded with an absolute target, moved by a signed offset taken from the current instruction, moved by one, or left where it is.

A single adder serves both the step and the relative branch. Its second operand is either the constant one or the sign-extended offset field. A final selector can replace the adder result with the jump target. A synchronous active-low clear sits in front of everything else. All arithmetic wraps modulo 2^16 and no overflow indication is produced.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_q` becomes 0x0000 after that edge, whatever the other inputs are.
- R2: With `rst_n` high and `jmp_sel` high, `pc_q` takes `jmp_tgt` after the edge. `br_sel`, `inc_en` and `br_off` have no effect on that cycle.
- R3: With `rst_n` high, `jmp_sel` low and `br_sel` high, `pc_q` becomes its old value plus `br_off` read as an 8-bit two's-complement number.
- R4: An offset with bit 7 set moves the counter backwards. 0x80 subtracts 128 and 0xFF subtracts 1, because the offset is sign-extended to 16 bits before the add.
- R5: With `rst_n` high, `jmp_sel` and `br_sel` low and `inc_en` high, `pc_q` increases by exactly one.
- R6: With `rst_n` high and `jmp_sel`, `br_sel` and `inc_en` all low, `pc_q` keeps its value.
- R7: Both the step and the branch wrap modulo 2^16. 0xFFFF steps to 0x0000, and a branch that crosses either end of the address space wraps around without any flag.
- R8: When `br_sel` and `inc_en` are both high and `jmp_sel` is low, the branch result is used and the extra step of one is not added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| jmp_sel | input | 1 | Load the absolute target this cycle |
| br_sel | input | 1 | Add the signed offset this cycle |
| inc_en | input | 1 | Advance by one when no jump or branch is selected |
| br_off | input | 8 | Two's-complement branch offset from the instruction |
| jmp_tgt | input | 16 | Absolute jump target |
| pc_q | output | 16 | Current program counter |

## Verification
Any pair of selects can be high in the same cycle. The most telling pairs are a branch with a step, where one adder must choose a single operand, and a jump with a branch, where the jump must win. The bench first parks the counter at a known base with a jump. It then applies every one of the sixteen combinations of clear, jump, branch and step, and compares the new value with the one that the priority order in R1, R2, R3, R5 and R6 implies. A full sweep of all 256 offsets runs with the step enable toggling alongside, which checks sign extension and shows that the step never adds to a branch.

// File: rtl/pcu_pkg.sv
// Shared types for the program counter next-address unit.
// Assumes: only the four actions below exist; clear is handled at the register.
package pcu_pkg;
    typedef enum logic [1:0] {
        PCU_HOLD   = 2'd0,
        PCU_STEP   = 2'd1,
        PCU_BRANCH = 2'd2,
        PCU_JUMP   = 2'd3
    } pcu_action_e;
endpackage

// File: rtl/pcu_decode.sv
// Reduces the three selects to one action, with jump over branch over step.
// Assumes: the selects are already decoded and stable before the clock edge.
module pcu_decode
    import pcu_pkg::*;
(
    input  logic        jmp_sel,
    input  logic        br_sel,
    input  logic        inc_en,
    output pcu_action_e action
);
    // Fixed priority choice of the next-address action.
    always_comb begin
        if (jmp_sel)      action = PCU_JUMP;
        else if (br_sel)  action = PCU_BRANCH;
        else if (inc_en)  action = PCU_STEP;
        else              action = PCU_HOLD;
    end
endmodule

// File: rtl/pcu_operand_sel.sv
// Builds the adder's second operand: one for a step, sign-extended offset for a branch.
// Assumes: OFF_W <= PC_W; the offset is two's-complement.
module pcu_operand_sel #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             use_off,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  operand
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            // Replicate the offset sign bit into the upper bits.
            always_comb off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_same
            // Offset already spans the full counter width.
            always_comb off_ext = off[PC_W-1:0];
        end
    endgenerate

    // Pick the constant one or the extended offset.
    always_comb operand = use_off ? off_ext : PC_W'(1);
endmodule

// File: rtl/pcu_adder.sv
// Modular adder for the counter; the carry out is discarded so results wrap.
// Assumes: both operands already have the counter width.
module pcu_adder #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] a,
    input  logic [PC_W-1:0] b,
    output logic [PC_W-1:0] sum
);
    // Wrapping sum, width equal to the counter.
    always_comb sum = a + b;
endmodule

// File: rtl/pc_next_unit.sv
// Program counter register with next-address selection.
// Order: synchronous clear, then jump load, then offset add, then step, else hold.
// Assumes: rst_n is synchronous to clk; all selects come from outside decoding.
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jmp_sel,
    input  logic             br_sel,
    input  logic             inc_en,
    input  logic [OFF_W-1:0] br_off,
    input  logic [PC_W-1:0]  jmp_tgt,
    output logic [PC_W-1:0]  pc_q
);
    pcu_action_e     action;
    logic [PC_W-1:0] add_b;
    logic [PC_W-1:0] add_sum;
    logic [PC_W-1:0] pc_d;

    pcu_decode i_decode (
        .jmp_sel (jmp_sel),
        .br_sel  (br_sel),
        .inc_en  (inc_en),
        .action  (action)
    );

    pcu_operand_sel #(.PC_W(PC_W), .OFF_W(OFF_W)) i_operand (
        .use_off (action == PCU_BRANCH),
        .off     (br_off),
        .operand (add_b)
    );

    pcu_adder #(.PC_W(PC_W)) i_adder (
        .a   (pc_q),
        .b   (add_b),
        .sum (add_sum)
    );

    // Final selector: target, adder result or current value.
    always_comb begin
        unique case (action)
            PCU_JUMP:              pc_d = jmp_tgt;
            PCU_BRANCH, PCU_STEP:  pc_d = add_sum;
            default:               pc_d = pc_q;
        endcase
    end

    // Counter register with synchronous power-on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R2
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_sel |=> pc_q == $past(jmp_tgt));

    // R3
    branch_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp_sel && br_sel) |=>
            pc_q == PC_W'($past(pc_q) + PC_W'($signed($past(br_off)))));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp_sel && !br_sel && inc_en) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

    // R6
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp_sel && !br_sel && !inc_en) |=> $stable(pc_q));

    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp_sel && !br_sel && inc_en && pc_q == '1) |=> pc_q == '0);
endmodule

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        jmp_sel, br_sel, inc_en;
    logic [7:0]  br_off;
    logic [15:0] jmp_tgt;
    logic [15:0] pc_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_next_unit i_pc_next_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .jmp_sel (jmp_sel),
        .br_sel  (br_sel),
        .inc_en  (inc_en),
        .br_off  (br_off),
        .jmp_tgt (jmp_tgt),
        .pc_q    (pc_q)
    );

    function automatic logic [15:0] sext(input logic [7:0] o);
        return {{8{o[7]}}, o};
    endfunction

    // Apply inputs after a falling edge, then sample one unit after the rising edge.
    task automatic cyc(input logic r, input logic j, input logic b, input logic i,
                       input logic [7:0] o, input logic [15:0] t);
        @(negedge clk);
        rst_n = r; jmp_sel = j; br_sel = b; inc_en = i; br_off = o; jmp_tgt = t;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (pc_q !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, pc_q, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; jmp_sel = 0; br_sel = 0; inc_en = 0; br_off = 0; jmp_tgt = 0;
        // R1: clear wins even with every other select high
        cyc(0, 1, 1, 1, 8'h10, 16'hBEEF);
        check("R1 reset clear", 16'h0000);
        cyc(1, 0, 0, 1, 8'h00, 16'h0000);
        check("R5 first step after clear", 16'h0001);

        // Sweep of all control combinations from a known base
        for (int c = 0; c < 16; c++) begin
            logic r, j, b, i;
            logic [15:0] exp;
            string tag;
            r = c[3]; j = c[2]; b = c[1]; i = c[0];
            cyc(1, 1, 0, 0, 8'h00, 16'h1234);
            check("R2 jump to base", 16'h1234);
            cyc(r, j, b, i, 8'hF0, 16'hABCD);
            if (!r)      begin exp = 16'h0000; tag = "R1 clear priority"; end
            else if (j)  begin exp = 16'hABCD; tag = "R2 jump priority"; end
            else if (b)  begin exp = 16'h1234 - 16'd16;
                               tag = i ? "R8 branch over step" : "R3 branch"; end
            else if (i)  begin exp = 16'h1235; tag = "R5 step"; end
            else         begin exp = 16'h1234; tag = "R6 hold"; end
            check(tag, exp);
        end

        // Every offset, with the step enable toggling alongside
        for (int o = 0; o < 256; o++) begin
            logic [7:0] ov;
            ov = o[7:0];
            cyc(1, 1, 0, 0, 8'h00, 16'h8000);
            cyc(1, 0, 1, ov[0], ov, 16'h0000);
            check(ov[7] ? "R4 negative offset" : "R3 R8 positive offset",
                  16'h8000 + sext(ov));
        end

        // Wrap at both ends of the address space
        cyc(1, 1, 0, 0, 8'h00, 16'hFFFF);
        cyc(1, 0, 0, 1, 8'h00, 16'h0000);
        check("R7 step wraps", 16'h0000);
        cyc(1, 1, 0, 0, 8'h00, 16'h0005);
        cyc(1, 0, 1, 0, 8'h80, 16'h0000);
        check("R7 R4 backward branch wraps", 16'hFF85);
        cyc(1, 1, 0, 0, 8'h00, 16'hFFF0);
        cyc(1, 0, 1, 1, 8'h7F, 16'h0000);
        check("R7 forward branch wraps", 16'h006F);
        cyc(1, 0, 1, 0, 8'hFF, 16'h0000);
        check("R4 offset FF is minus one", 16'h006E);

        // Hold over several idle cycles, offset and target changing
        for (int k = 0; k < 5; k++) begin
            cyc(1, 0, 0, 0, 8'(k * 37), 16'(k * 4099));
            check("R6 idle hold", 16'h006E);
        end

        done = 1;
        finish_run();
    end
endmodule